// File: doc/BRIEF.md
# Feature Unlock Sequence Controller

This block keeps a strong-crypto capability switched off until a host completes a register-level unlock handshake. The host reaches it over a simple register bus with separate read and write strobes, a word address and 32-bit data. It holds a RAM configuration register, a DMA configuration register, a read-only seed register, a write-only secret register and a crypto level status register. The level register reports whether the feature is still locked, has been unlocked, or has been locked out until reset.

The host unlocks the feature in four steps. It writes the key value 0x807 to the DMA configuration register. It reads the seed. It writes zero to the secret register to arm the sequence. It then writes thirteen signatures. Each signature is the previous value advanced through a 32-bit LFSR. The first one starts from the seed. Step i advances the value by (id[i] + 0x101) steps, where id is a fixed 13-byte identity parameter. The LFSR shifts left by one bit and puts the parity of (value AND 0x80080125) into bit 0.

The controller computes each expected signature with one serial LFSR stepper, one step per clock, and raises `busy` while it does so. A wrong signature, a write while busy, or any secret write once unlocked moves the controller to a locked-out state. Only reset clears that state.

Top module: `unlock_ctrl`

## Requirements
- R1: The level register (address 1) reads 0x00000000 whenever bit 5 of the RAM configuration register (address 0) is clear.
- R2: After reset, with bit 5 set and no unlock done, the level register reads 0x00003020.
- R3: After a successful unlock, with bit 5 set, the level register reads 0x00001120 while `full_strap` is high and 0x00001020 while it is low.
- R4: After reset, the RAM configuration and DMA configuration registers (address 2) read 0, and `busy` is low. Both registers read back the last value written. The seed register (address 3) always reads the SEED parameter.
- R5: A write to the secret register (address 4) is ignored unless the DMA configuration register holds 0x807.
- R6: In the idle state, a zero written to the secret register arms the sequence at index 0. A nonzero write in that state is ignored. Each start of a computation holds `busy` high for exactly id[i] + 0x101 cycles, counted from the write edge.
- R7: Signature i must equal the previous value, or the seed for i = 0, advanced by id[i] + 0x101 LFSR steps, with id[i] = CARD_ID[8i+7:8i]. Thirteen matching signatures unlock the feature.
- R8: A signature that does not match moves the controller to lockout. There the level register reads 0, and further secret writes start nothing, until reset.
- R9: A secret write accepted while `busy` is high counts as a mismatch and moves the controller to lockout.
- R10: Any secret write accepted after a successful unlock moves the controller to lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Word address |
| wdata | input | 32 | Write data |
| full_strap | input | 1 | Selects the full tier over the DES-only tier |
| rdata | output | 32 | Read data, valid in the cycle of `rd_en`, zero otherwise |
| busy | output | 1 | Expected-signature computation in progress |

## Verification
The main function is tried with several kinds of signature streams. A fully correct chain checks the LFSR arithmetic and the per-step counts over an identity table that includes the byte values 0x00 and 0xFF. A chain that is correct except for its last word checks that the match of the final word is really tested. A write sent while the stepper is still running checks the busy rule. A second arm after success checks the re-unlock rule. Secret writes with the wrong DMA key, and a nonzero write before arming, check that such writes neither arm the sequence nor change the level. A reference model that runs every cycle compares `busy` on every clock, so an off-by-one in the step count shows up.

// File: rtl/unlock_pkg.sv
package unlock_pkg;
  localparam int DW = 32;
  localparam int AW = 3;

  localparam logic [AW-1:0] A_RAMCFG = 3'd0;
  localparam logic [AW-1:0] A_LEVEL  = 3'd1;
  localparam logic [AW-1:0] A_DMACFG = 3'd2;
  localparam logic [AW-1:0] A_SEED   = 3'd3;
  localparam logic [AW-1:0] A_SECRET = 3'd4;

  localparam logic [DW-1:0] DMA_KEY  = 32'h0000_0807;
  localparam logic [DW-1:0] LVL_NONE = 32'h0000_3020;
  localparam logic [DW-1:0] LVL_DES  = 32'h0000_1020;
  localparam logic [DW-1:0] LVL_FULL = 32'h0000_1120;
  localparam logic [DW-1:0] LFSR_TAP = 32'h8008_0125;
  localparam int            STEP_BASE = 257;
  localparam int            LVL_GATE_BIT = 5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_OPEN = 2'd2,
    ST_LOCK = 2'd3
  } unlock_state_t;

  function automatic logic [DW-1:0] lfsr_step(input logic [DW-1:0] a);
    return {a[DW-2:0], ^(a & LFSR_TAP)};
  endfunction
endpackage

// File: rtl/lfsr_stepper.sv
module lfsr_stepper
  import unlock_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] start_val,
  input  logic [CW-1:0] steps,
  output logic          busy,
  output logic [DW-1:0] value
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] val_q, val_d;
  logic          en;

  assign busy  = (cnt_q != '0);
  assign value = val_q;
  assign en    = start | busy;

  always_comb begin
    cnt_d = cnt_q;
    val_d = val_q;
    if (start) begin
      cnt_d = steps;
      val_d = start_val;
    end else if (busy) begin
      cnt_d = cnt_q - CW'(1);
      val_d = lfsr_step(val_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      val_q <= '0;
    end else if (en) begin
      cnt_q <= cnt_d;
      val_q <= val_d;
    end
  end

  // R6
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && steps != '0) |=> busy);
  // R6
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (value == lfsr_step($past(value))));
endmodule

// File: rtl/unlock_seq_fsm.sv
module unlock_seq_fsm
  import unlock_pkg::*;
#(
  parameter int                   NUM_SIG = 13,
  parameter int                   CW      = 10,
  parameter logic [DW-1:0]        SEED    = 32'h1234_5678,
  parameter logic [8*NUM_SIG-1:0] CARD_ID = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sec_wr,
  input  logic [DW-1:0] wdata,
  input  logic          busy,
  input  logic [DW-1:0] cur_val,
  output logic          start,
  output logic [DW-1:0] start_val,
  output logic [CW-1:0] steps,
  output unlock_state_t state
);
  localparam int           IW   = $clog2(NUM_SIG + 1);
  localparam logic [IW-1:0] LAST = IW'(NUM_SIG - 1);

  unlock_state_t st_q, st_d;
  logic [IW-1:0] idx_q, idx_d, id_sel;
  logic          upd;

  assign state = st_q;
  assign upd   = sec_wr;

  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    start     = 1'b0;
    start_val = cur_val;
    id_sel    = idx_q;
    case (st_q)
      ST_IDLE: if (sec_wr && wdata == '0) begin
        st_d      = ST_RUN;
        idx_d     = '0;
        id_sel    = '0;
        start     = 1'b1;
        start_val = SEED;
      end
      ST_RUN: if (sec_wr) begin
        if (busy || wdata != cur_val) begin
          st_d = ST_LOCK;
        end else if (idx_q == LAST) begin
          st_d = ST_OPEN;
        end else begin
          idx_d  = idx_q + IW'(1);
          id_sel = idx_q + IW'(1);
          start  = 1'b1;
        end
      end
      ST_OPEN: if (sec_wr) st_d = ST_LOCK;
      default: ;
    endcase
  end

  assign steps = CW'(CARD_ID[int'(id_sel)*8 +: 8]) + CW'(STEP_BASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else if (upd) begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  // R8
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOCK) |=> (st_q == ST_LOCK));
  // R9
  busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && sec_wr && busy) |=> (st_q == ST_LOCK));
  // R10
  reunlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OPEN && sec_wr) |=> (st_q == ST_LOCK));
  // R7
  open_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && sec_wr && !busy && wdata == cur_val && idx_q == LAST)
      |=> (st_q == ST_OPEN));
endmodule

// File: rtl/unlock_ctrl.sv
module unlock_ctrl
  import unlock_pkg::*;
#(
  parameter int                   NUM_SIG = 13,
  parameter logic [DW-1:0]        SEED    = 32'h1234_5678,
  parameter logic [8*NUM_SIG-1:0] CARD_ID = 104'hFF_5A_3C_00_81_7E_12_C4_09_E7_66_20_00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          full_strap,
  output logic [DW-1:0] rdata,
  output logic          busy
);
  localparam int CW = $clog2(255 + STEP_BASE + 1);

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic [DW-1:0] ram_q, dma_q, level, cur_val, start_val;
  logic          ram_we, dma_we, sec_wr, start;
  logic [CW-1:0] steps;
  unlock_state_t state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign ram_we = wr_en && (addr == A_RAMCFG);
  assign dma_we = wr_en && (addr == A_DMACFG);
  assign sec_wr = wr_en && (addr == A_SECRET) && (dma_q == DMA_KEY);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ram_q <= '0;
      dma_q <= '0;
    end else begin
      if (ram_we) ram_q <= wdata;
      if (dma_we) dma_q <= wdata;
    end
  end

  unlock_seq_fsm #(
    .NUM_SIG(NUM_SIG), .CW(CW), .SEED(SEED), .CARD_ID(CARD_ID)
  ) u_fsm (
    .clk(clk), .rst_n(rst_int_n), .sec_wr(sec_wr), .wdata(wdata),
    .busy(busy), .cur_val(cur_val), .start(start), .start_val(start_val),
    .steps(steps), .state(state)
  );

  lfsr_stepper #(.CW(CW)) u_step (
    .clk(clk), .rst_n(rst_int_n), .start(start), .start_val(start_val),
    .steps(steps), .busy(busy), .value(cur_val)
  );

  always_comb begin
    level = '0;
    if (ram_q[LVL_GATE_BIT]) begin
      case (state)
        ST_OPEN: level = full_strap ? LVL_FULL : LVL_DES;
        ST_LOCK: level = '0;
        default: level = LVL_NONE;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_RAMCFG: rdata = ram_q;
        A_LEVEL:  rdata = level;
        A_DMACFG: rdata = dma_q;
        A_SEED:   rdata = SEED;
        default:  rdata = '0;
      endcase
    end
  end

  // R5
  key_gate_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && addr == A_SECRET && dma_q != DMA_KEY && !busy) |=> ($stable(state) && !busy));
  // R1
  level_gate_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_en && addr == A_LEVEL && !ram_q[LVL_GATE_BIT]) |-> (rdata == '0));
endmodule

// File: tb/test_unlock_ctrl.sv
`timescale 1ns/1ps
module test_unlock_ctrl;
  localparam logic [31:0]  SEED = 32'h1234_5678;
  localparam logic [103:0] CID  = 104'hFF_5A_3C_00_81_7E_12_C4_09_E7_66_20_00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, full_strap = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic busy;

  int checks = 0, fails = 0, cyc = 0;

  int m_st, m_idx, m_bcnt;
  logic [31:0] m_ram, m_dma, m_val;

  unlock_ctrl #(.SEED(SEED), .CARD_ID(CID)) i_unlock_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .full_strap(full_strap), .rdata(rdata), .busy(busy)
  );

  always #10 clk = ~clk;

  function automatic int idb(int i);
    return int'(CID[i*8 +: 8]);
  endfunction

  function automatic logic [31:0] adv(logic [31:0] a, int n);
    logic [31:0] v = a;
    for (int k = 0; k < n; k++) begin
      int p = 0;
      for (int b = 0; b < 32; b++) if (((v & 32'h8008_0125) >> b) & 1) p ^= 1;
      v = (v << 1) ^ 32'(p);
    end
    return v;
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model, updated every clock
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_idx = 0; m_bcnt = 0; m_ram = 0; m_dma = 0; m_val = 0;
    end else begin
      bit sec, bz;
      sec = wr_en && addr == 3'd4 && m_dma == 32'h807;
      bz  = (m_bcnt != 0);
      if (m_bcnt != 0) m_bcnt--;
      if (wr_en && addr == 3'd0) m_ram = wdata;
      if (wr_en && addr == 3'd2) m_dma = wdata;
      if (sec) begin
        case (m_st)
          0: if (wdata == 0) begin
               m_st = 1; m_idx = 0;
               m_bcnt = idb(0) + 257;
               m_val = adv(SEED, idb(0) + 257);
             end
          1: if (bz || wdata != m_val) m_st = 3;
             else if (m_idx == 12) m_st = 2;
             else begin
               m_idx++;
               m_bcnt = idb(m_idx) + 257;
               m_val = adv(m_val, idb(m_idx) + 257);
             end
          2: m_st = 3;
          default: ;
        endcase
      end
    end
  end

  // per-clock busy comparison (R6)
  always @(negedge clk) begin
    if (rst_n) chk({31'd0, busy}, {31'd0, m_bcnt != 0}, "R6 busy");
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL R7 watchdog actual=%0d expected<150000", cyc);
      summary();
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] exp, string tag);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #2 chk(rdata, exp, tag);
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic good_chain(int upto);
    wr(3'd2, 32'h807);
    wr(3'd4, 32'd0);
    for (int i = 0; i < upto; i++) begin
      wait_idle();
      wr(3'd4, m_val);
    end
  endtask

  initial begin
    do_reset();
    // R4 reset state
    rd(3'd0, 32'd0, "R4 ramcfg reset");
    rd(3'd2, 32'd0, "R4 dmacfg reset");
    rd(3'd3, SEED, "R4 seed");
    rd(3'd1, 32'd0, "R1 level gated");
    wr(3'd0, 32'h20);
    rd(3'd0, 32'h20, "R4 ramcfg readback");
    rd(3'd1, 32'h3020, "R2 level locked");
    // R5 wrong key: zero write ignored
    wr(3'd2, 32'h806);
    wr(3'd4, 32'd0);
    chk({31'd0, busy}, 32'd0, "R5 no arm");
    rd(3'd1, 32'h3020, "R5 level unchanged");
    // R6 nonzero write while idle ignored
    wr(3'd2, 32'h807);
    wr(3'd4, 32'h55);
    chk({31'd0, busy}, 32'd0, "R6 nonzero idle");
    // R8 mismatch on first signature
    wr(3'd4, 32'd0);
    wait_idle();
    wr(3'd4, m_val ^ 32'h1);
    rd(3'd1, 32'h0, "R8 lockout level");
    wr(3'd4, 32'd0);
    chk({31'd0, busy}, 32'd0, "R8 no restart");
    rd(3'd1, 32'h0, "R8 stays locked");

    // R7 full chain, R3 tiers, R1 gating
    do_reset();
    rd(3'd1, 32'h0, "R1 after reset");
    wr(3'd0, 32'h20);
    good_chain(13);
    rd(3'd1, 32'h1020, "R3 des tier");
    full_strap = 1'b1;
    rd(3'd1, 32'h1120, "R3 full tier");
    wr(3'd0, 32'h0);
    rd(3'd1, 32'h0, "R1 gated when unlocked");
    wr(3'd0, 32'h20);
    // R10 second unlock attempt
    wr(3'd4, 32'd0);
    rd(3'd1, 32'h0, "R10 relock");
    full_strap = 1'b0;

    // R9 write while busy
    do_reset();
    wr(3'd0, 32'h20);
    wr(3'd2, 32'h807);
    wr(3'd4, 32'd0);
    wr(3'd4, m_val);
    rd(3'd1, 32'h0, "R9 busy write");

    // R7 last signature wrong
    do_reset();
    wr(3'd0, 32'h20);
    good_chain(12);
    wait_idle();
    wr(3'd4, m_val ^ 32'h8000_0000);
    rd(3'd1, 32'h0, "R7 last mismatch");

    repeat (3) @(negedge clk);
    summary();
  end
endmodule